// File: doc/BRIEF.md
# Bank-Conflict Serializing Scratchpad

This block is a scratchpad memory shared by the 32 lanes of a warp. The scratchpad is split into 32 single-ported banks of 32-bit words. A request carries one word address per lane, a mask of active lanes, a read/write flag and one write word per lane. The block finds the bank that each active lane hits. It then serves the request over as many passes as the busiest bank needs, and returns the read data and the pass count in one response.

A pass is one clock cycle. In each pass every bank serves one distinct word. All pending lanes that name that word are served together, so a read is broadcast to every lane that names the word. The request therefore takes from one pass, when the active lanes spread over distinct banks, up to 32 passes, when every lane names a different word of one bank. The block accepts a new request only after it has sent the response to the current one.

Top module: `bank_serializer`

## Requirements
- R1: A word address selects its bank from its low 5 bits (address mod 32) and its row within that bank from the remaining upper bits. A word that is written can be read back unchanged at the same address.
- R2: A request in which all active lanes hit distinct banks is served in exactly 1 pass.
- R3: A full-mask request whose lane addresses step by 32 words puts all lanes in one bank and takes 32 passes.
- R4: A full-mask request whose lane addresses step by 33 words touches every bank once and takes 1 pass.
- R5: The pass count reported in `rspPasses` equals the largest number of distinct word addresses that the active lanes place in any single bank.
- R6: Active lanes that name the same word count as one access and all receive that word's data.
- R7: Inactive lanes add no passes and do not change memory, and their `rspData` slot reads as zero.
- R8: `reqReady` is high only when the block is idle. A request accepted at a clock edge raises `rspValid` for exactly one cycle, max(P,1) cycles after that edge, where P is the pass count. `reqReady` stays low from the acceptance until the cycle after `rspValid`.
- R9: When several active lanes write the same word in one request, the data of the highest-numbered of those lanes is stored.
- R10: After reset `reqReady` is 1, `rspValid` is 0 and `rspPasses` is 0.
- R11: A write request returns all-zero `rspData`. A request with an all-zero mask reports 0 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMask | input | 32 | Active-lane mask, bit l for lane l |
| reqAddr | input | 320 | Lane word addresses, lane l in bits [10l+9:10l] |
| reqWdata | input | 1024 | Lane write words, lane l in bits [32l+31:32l] |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 1024 | Lane read words, same packing as reqWdata |
| rspPasses | output | 6 | Number of passes used |

## Verification
The bench first writes and then reads back a set of strided patterns. The strides 1, 2, 16, 32, 33, 64 and 0 each have a known worst-bank depth. A design that took the bank from the wrong address bits, or counted repeated reads of one word as conflicts, would report a wrong pass count on these patterns. Directed cases then cover the following:
- A mixed pattern with a three-deep bank and a broadcast lane.
- Sparse masks over a conflicting pattern. A design that let inactive lanes count toward passes, or write memory, would show extra passes or corrupted neighbouring words.
- Two lanes that write one word. A design with the wrong priority would keep the lower lane's data.
- An empty mask.

Every request also times `rspValid` and watches `reqReady`, so an off-by-one pass loop shows up.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } bsmStrobe_t;
endpackage

// File: rtl/bsm_datapath.sv
module bsm_datapath
  import bsm_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bsmStrobe_t               strobe,
  input  logic                     reqWrite,
  input  logic [LANES-1:0]         reqMask,
  input  logic [LANES*ADDR_W-1:0]  reqAddr,
  input  logic [LANES*DATA_W-1:0]  reqWdata,
  output logic                     lastPass,
  output logic                     anyPending,
  output logic [LANES*DATA_W-1:0]  rspData
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;

  logic [ADDR_W-1:0] addrQ  [LANES];
  logic [DATA_W-1:0] dataQ  [LANES];
  logic [DATA_W-1:0] rdataQ [LANES];
  logic              writeQ;
  logic [LANES-1:0]  pending;
  logic [LANES-1:0]  served;

  logic [BANKS-1:0]  selValid;
  logic [ROW_W-1:0]  selRow     [BANKS];
  logic [DATA_W-1:0] bankWdata  [BANKS];
  logic [DATA_W-1:0] bankRdata  [BANKS];

  // Per bank: the lowest pending lane in that bank picks the row for this pass.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      selValid[b] = 1'b0;
      selRow[b]   = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && (int'(addrQ[l][BANK_W-1:0]) == b)) begin
          selValid[b] = 1'b1;
          selRow[b]   = addrQ[l][ADDR_W-1:BANK_W];
        end
      end
    end
  end

  // A lane is served when its row matches the row its bank picked this pass.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = pending[l] &&
                  (addrQ[l][ADDR_W-1:BANK_W] == selRow[addrQ[l][BANK_W-1:0]]);
    end
  end

  // Write data per bank: the highest served lane in the bank wins.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankWdata[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && (int'(addrQ[l][BANK_W-1:0]) == b)) bankWdata[b] = dataQ[l];
      end
    end
  end

  assign lastPass   = ((pending & ~served) == '0);
  assign anyPending = |pending;

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    logic [DATA_W-1:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (strobe.step && writeQ && selValid[b]) mem[selRow[b]] <= bankWdata[b];
    end
    assign bankRdata[b] = mem[selRow[b]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      writeQ  <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        rdataQ[l] <= '0;
        addrQ[l]  <= '0;
        dataQ[l]  <= '0;
      end
    end else if (strobe.load) begin
      pending <= reqMask;
      writeQ  <= reqWrite;
      for (int l = 0; l < LANES; l++) begin
        addrQ[l]  <= reqAddr[l*ADDR_W +: ADDR_W];
        dataQ[l]  <= reqWdata[l*DATA_W +: DATA_W];
        rdataQ[l] <= '0;
      end
    end else if (strobe.step) begin
      pending <= pending & ~served;
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && !writeQ) rdataQ[l] <= bankRdata[addrQ[l][BANK_W-1:0]];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : gOut
    assign rspData[l*DATA_W +: DATA_W] = rdataQ[l];
  end
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic                           lastPass,
  input  logic                           anyPending,
  output bsmStrobe_t                     strobe,
  output logic                           reqReady,
  output logic                           rspValid,
  output logic [$clog2(LANES+1)-1:0]     rspPasses
);
  localparam int PASS_W = $clog2(LANES + 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_RESP} state_t;
  state_t state;
  logic [PASS_W-1:0] passCnt;

  assign reqReady    = (state == S_IDLE);
  assign rspValid    = (state == S_RESP);
  assign rspPasses   = passCnt;
  assign strobe.load = (state == S_IDLE) && reqValid;
  assign strobe.step = (state == S_BUSY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      passCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          state   <= S_BUSY;
          passCnt <= '0;
        end
        S_BUSY: begin
          if (anyPending) passCnt <= passCnt + 1'b1;
          if (lastPass) state <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bank_serializer.sv
module bank_serializer
  import bsm_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [LANES-1:0]              reqMask,
  input  logic [LANES*ADDR_W-1:0]       reqAddr,
  input  logic [LANES*DATA_W-1:0]       reqWdata,
  output logic                          rspValid,
  output logic [LANES*DATA_W-1:0]       rspData,
  output logic [$clog2(LANES+1)-1:0]    rspPasses
);
  bsmStrobe_t strobe;
  logic lastPass;
  logic anyPending;

  bsm_ctrl #(.LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lastPass(lastPass),
    .anyPending(anyPending), .strobe(strobe), .reqReady(reqReady),
    .rspValid(rspValid), .rspPasses(rspPasses)
  );

  bsm_datapath #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .lastPass(lastPass), .anyPending(anyPending), .rspData(rspData)
  );
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int LANES = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic                        reqReady,
  input logic [LANES-1:0]            reqMask,
  input logic                        rspValid,
  input logic [$clog2(LANES+1)-1:0]  rspPasses
);
  // R8: the response strobe lasts one cycle
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R8: no acceptance while a response is out
  a_r8_ready_low_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);
  // R8: ready drops right after an acceptance
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R5: pass count never exceeds the lane count
  a_r5_pass_bound: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (int'(rspPasses) <= LANES));
  // R11: an empty mask answers two cycles later with zero passes
  a_r11_empty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqMask == '0)) |=> ##1 (rspValid && rspPasses == '0));
  // R2: a single active lane is one pass
  a_r2_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && $countones(reqMask) == 1) |=> ##1 (rspValid && rspPasses == 1));
endmodule

bind bank_serializer bsm_checker #(.LANES(LANES)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqMask(reqMask), .rspValid(rspValid), .rspPasses(rspPasses)
);

// File: tb/sim_bank_serializer.sv
module sim_bank_serializer;
  localparam int LANES  = 32;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int PASS_W = $clog2(LANES + 1);
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 1 << ADDR_W;

  localparam int VEC_N = 7;
  localparam int V_STRIDE [VEC_N] = '{1, 32, 33, 2, 0, 16, 64};
  localparam int V_BASE   [VEC_N] = '{0,  3,  5, 100, 77, 1, 9};
  localparam int V_PASSES [VEC_N] = '{1, 32,  1, 2, 1, 16, 16};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [LANES-1:0] reqMask = '0;
  logic [LANES*ADDR_W-1:0] reqAddr = '0;
  logic [LANES*DATA_W-1:0] reqWdata = '0;
  logic rspValid;
  logic [LANES*DATA_W-1:0] rspData;
  logic [PASS_W-1:0] rspPasses;

  int checks = 0;
  int errors = 0;
  int addrV [LANES];
  logic [DATA_W-1:0] wdatV [LANES];
  logic [DATA_W-1:0] rdV [LANES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_serializer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqMask(reqMask), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspPasses(rspPasses)
  );

  function automatic logic [DATA_W-1:0] pat(int a, int salt);
    return 32'h5A000000 ^ DATA_W'(a << 12) ^ DATA_W'(a) ^ DATA_W'(salt << 24);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runReq(input logic wr, input logic [LANES-1:0] m, output int passes, output int lat);
    int cyc = 0;
    bit sawReady = 0;
    @(negedge clk);
    check(reqReady == 1'b1, "R8 idle ready", reqReady, 1);
    reqValid = 1'b1;
    reqWrite = wr;
    reqMask  = m;
    for (int l = 0; l < LANES; l++) begin
      reqAddr[l*ADDR_W +: ADDR_W]  = ADDR_W'(addrV[l]);
      reqWdata[l*DATA_W +: DATA_W] = wdatV[l];
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    while (!rspValid && cyc < 100) begin
      if (reqReady) sawReady = 1;
      @(negedge clk);
      cyc++;
    end
    if (reqReady) sawReady = 1;
    check(!sawReady, "R8 ready low while busy", sawReady, 0);
    passes = int'(rspPasses);
    lat = cyc;
    for (int l = 0; l < LANES; l++) rdV[l] = rspData[l*DATA_W +: DATA_W];
    @(negedge clk);
    check(!rspValid, "R8 single-cycle response", rspValid, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int p;
    int lat;
    int expP;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(reqReady == 1'b1 && rspValid == 1'b0 && rspPasses == '0, "R10", {reqReady, rspValid, rspPasses}, 8'h80);

    // Table walk: write then read back each strided pattern (R1..R5, R6, R8, R11)
    for (int v = 0; v < VEC_N; v++) begin
      for (int l = 0; l < LANES; l++) begin
        addrV[l] = (V_BASE[v] + l * V_STRIDE[v]) % WORDS;
        wdatV[l] = pat(addrV[l], 0);
      end
      runReq(1'b1, '1, p, lat);
      check(p == V_PASSES[v], "R5 write passes", p, V_PASSES[v]);
      expP = (V_PASSES[v] < 1) ? 1 : V_PASSES[v];
      check(lat == expP + 1, "R8 latency", lat, expP + 1);
      for (int l = 0; l < LANES; l++)
        if (rdV[l] != '0) begin
          check(1'b0, "R11 write returns zero", rdV[l], 0);
          break;
        end
      runReq(1'b0, '1, p, lat);
      if (V_STRIDE[v] == 32) check(p == 32, "R3 stride-32 passes", p, 32);
      else if (V_STRIDE[v] == 33) check(p == 1, "R4 stride-33 passes", p, 1);
      else if (V_STRIDE[v] == 0) check(p == 1, "R6 broadcast passes", p, 1);
      else if (V_STRIDE[v] == 1) check(p == 1, "R2 distinct banks", p, 1);
      else check(p == V_PASSES[v], "R5 read passes", p, V_PASSES[v]);
      for (int l = 0; l < LANES; l++)
        check(rdV[l] == pat(addrV[l], 0), "R1 readback", rdV[l], pat(addrV[l], 0));
    end

    // R5 mixed: bank 12 holds three distinct words, lane 3 repeats lane 0 (R6)
    for (int l = 0; l < LANES; l++) addrV[l] = 300 + l;
    addrV[1] = 332; addrV[2] = 364; addrV[3] = 300;
    for (int l = 0; l < LANES; l++) wdatV[l] = pat(addrV[l], 0);
    runReq(1'b1, '1, p, lat);
    check(p == 3, "R5 mixed write passes", p, 3);
    runReq(1'b0, '1, p, lat);
    check(p == 3, "R5 mixed read passes", p, 3);
    check(lat == 4, "R8 mixed latency", lat, 4);
    check(rdV[3] == pat(300, 0) && rdV[0] == rdV[3], "R6 broadcast data", rdV[3], pat(300, 0));
    check(rdV[2] == pat(364, 0), "R1 mixed data", rdV[2], pat(364, 0));

    // R7 masked write leaves other lanes' words untouched
    for (int l = 0; l < LANES; l++) begin addrV[l] = 200 + l; wdatV[l] = pat(addrV[l], 0); end
    runReq(1'b1, '1, p, lat);
    for (int l = 0; l < LANES; l++) wdatV[l] = pat(addrV[l], 1);
    runReq(1'b1, 32'h1, p, lat);
    check(p == 1, "R7 masked write passes", p, 1);
    runReq(1'b0, '1, p, lat);
    check(rdV[0] == pat(200, 1), "R7 active lane written", rdV[0], pat(200, 1));
    for (int l = 1; l < LANES; l++)
      check(rdV[l] == pat(200 + l, 0), "R7 inactive lane untouched", rdV[l], pat(200 + l, 0));

    // R7 sparse mask over stride-32 pattern: two lanes, two passes, rest zero
    for (int l = 0; l < LANES; l++) addrV[l] = 3 + 32 * l;
    runReq(1'b0, 32'h21, p, lat);
    check(p == 2, "R7 sparse passes", p, 2);
    check(rdV[0] == pat(3, 0), "R7 lane0 data", rdV[0], pat(3, 0));
    check(rdV[5] == pat(163, 0), "R7 lane5 data", rdV[5], pat(163, 0));
    check(rdV[6] == '0 && rdV[31] == '0, "R7 inactive zero", rdV[6], 0);

    // R9 two lanes write one word: higher lane wins
    for (int l = 0; l < LANES; l++) begin addrV[l] = 500; wdatV[l] = '0; end
    wdatV[3]  = 32'h1111_0003;
    wdatV[20] = 32'h2222_0014;
    runReq(1'b1, (32'h1 << 3) | (32'h1 << 20), p, lat);
    check(p == 1, "R9 dup write passes", p, 1);
    runReq(1'b0, 32'h1, p, lat);
    check(rdV[0] == 32'h2222_0014, "R9 highest lane kept", rdV[0], 32'h2222_0014);

    // R11 empty mask
    runReq(1'b0, '0, p, lat);
    check(p == 0, "R11 empty mask passes", p, 0);
    check(lat == 2, "R8 empty mask latency", lat, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule